// File: doc/BRIEF.md
# Pseudorandom Logic Self-Test Engine

This block runs a closed logic self-test on a small combinational circuit. A one-cycle start request seeds an 8-bit pseudorandom pattern generator and clears an 8-stage signature register. For the next 255 cycles the generator walks through every non-zero state of its maximal-length sequence. Each pattern drives one of two built-in circuits under test: a 4-bit adder or a 3-to-8 decoder. The response of the chosen circuit is folded into the signature register on every cycle.

When the sequence has been applied, the final signature is compared with a golden constant for the selected circuit. The engine then drops busy and raises done, together with a pass flag. Both flags and the signature stay as they are until the next start. A fault-injection input forces one response bit to a fixed value, so that a failing run can be exercised on demand.

The circuit choice and the fault setting are captured when the run starts. Start requests that arrive while a run is in progress are ignored.

Top module: `lbist_engine`

## Requirements
- R1: While reset is asserted and after it is released, busy, done and pass read 0 and the signature reads 8'h00, until the first start.
- R2: When start is high at a clock edge while busy is low, busy is 1 after that edge and done and pass are 0. Busy then stays high for exactly 255 cycles. Done rises on the edge at which busy falls, and busy and done are never 1 together.
- R3: The pattern generator is seeded with 8'h01 on start. It shifts left, and its new bit 0 is the XOR of bits 7, 5, 4 and 3 (polynomial x^8+x^6+x^5+x^4+1). It advances exactly once per busy cycle, is never zero, and holds its state when idle.
- R4: With cut_sel = 0 (adder), the response is pattern[3:0] + pattern[7:4] as a 5-bit sum with carry, zero-extended to 8 bits.
- R5: With cut_sel = 1 (decoder), the response is a one-hot byte with bit pattern[2:0] set. Pattern bits 7..3 have no effect on it.
- R6: The signature register is cleared to 0 on start. On each busy cycle it takes the value {sig[6:0], sig[7]^sig[5]^sig[4]^sig[3]} XOR response.
- R7: In a fault-free run the final signature equals the golden constant for the selected circuit, and pass is 1 when done rises. Pass is never 1 while done is 0.
- R8: With inject_fault = 1, response bit 0 is forced to 1 on every cycle of the run. Pass is 1 only if the resulting signature still equals the golden constant.
- R9: After a run, done, pass and signature keep their values until the next accepted start, whatever cut_sel and inject_fault do.
- R10: cut_sel and inject_fault are sampled at the accepted start. Changing them during a run, or pulsing start during a run, does not change the run's length or its final signature.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request to begin a self-test run; accepted only when idle |
| cut_sel | input | 1 | Circuit under test: 0 adder, 1 decoder |
| inject_fault | input | 1 | Forces response bit 0 to 1 for the run |
| busy | output | 1 | A run is in progress |
| done | output | 1 | A run has finished; held until the next start |
| pass | output | 1 | Final signature matched the golden constant |
| signature | output | 8 | Contents of the signature register |

## Verification
The embedded properties check the following on every clock: the generator never reaches zero and moves on every busy cycle, the decoder response stays one-hot, the signature clears on start, busy and done never overlap, pass never appears without done, and done and signature hold once a run ends. Whether a 255-cycle run produces the right signature, and whether the pass flag is correct for each circuit and fault setting, can only be shown by complete runs. The bench therefore compares whole runs against an independent software model. It uses random selections, mid-run input changes and spurious start pulses.

// File: rtl/lbist_pkg.sv
package lbist_pkg;

   typedef enum logic {
      CUT_ADDER   = 1'b0,
      CUT_DECODER = 1'b1
   } cut_kind_e;

   localparam logic [7:0] DEF_TAPS = 8'hB8;
   localparam logic [7:0] DEF_SEED = 8'h01;
   localparam int         DEF_LEN  = 255;

   // Constant function: signature of a complete run, evaluated at elaboration.
   function automatic logic [7:0] ref_signature(input logic dec, input logic flt,
                                                input logic [7:0] taps,
                                                input logic [7:0] seed,
                                                input int len);
      logic [7:0] pat;
      logic [7:0] acc;
      logic [7:0] rsp;
      pat = seed;
      acc = 8'h00;
      for (int k = 0; k < len; k++) begin
         if (dec) rsp = 8'h01 << pat[2:0];
         else     rsp = {3'b000, {1'b0, pat[3:0]} + {1'b0, pat[7:4]}};
         if (flt) rsp[0] = 1'b1;
         acc = {acc[6:0], ^(acc & taps)} ^ rsp;
         pat = {pat[6:0], ^(pat & taps)};
      end
      return acc;
   endfunction

endpackage

// File: rtl/lbist_prpg.sv
module lbist_prpg #(
   parameter int         W    = 8,
   parameter logic [W-1:0] TAPS = 8'hB8,
   parameter logic [W-1:0] SEED = 8'h01
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         load,
   input  logic         step,
   output logic [W-1:0] state
);

   initial begin
      if (W < 8)     $error("lbist_prpg: W must be at least 8");
      if (SEED == 0) $error("lbist_prpg: SEED must be non-zero");
      if (TAPS == 0) $error("lbist_prpg: TAPS must be non-zero");
   end

   logic fb;
   assign fb = ^(state & TAPS);

   always_ff @(posedge clk) begin
      if (rst)       state <= SEED;
      else if (load) state <= SEED;
      else if (step) state <= {state[W-2:0], fb};
   end

   // R3
   prpg_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
      step |=> state != '0);
   // R3
   prpg_moves_chk: assert property (@(posedge clk) disable iff (rst)
      (step && !load) |=> state != $past(state));
   // R3
   prpg_idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (!step && !load) |=> $stable(state));

endmodule

// File: rtl/lbist_cut.sv
module lbist_cut #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] pattern,
   input  logic         sel_dec,
   input  logic         flt,
   output logic [W-1:0] resp
);
   import lbist_pkg::*;

   localparam int NIB    = 4;
   localparam int DEC_IN = 3;
   localparam int DEC_N  = 1 << DEC_IN;

   initial begin
      if (W < 2 * NIB) $error("lbist_cut: W too small for adder operands");
      if (W < DEC_N)   $error("lbist_cut: W too small for decoder outputs");
   end

   logic [W-1:0]   add_out;
   logic [W-1:0]   dec_out;
   logic [NIB:0]   sum;
   logic [W-1:0]   raw;

   assign sum = {1'b0, pattern[NIB-1:0]} + {1'b0, pattern[2*NIB-1:NIB]};
   assign add_out = {{(W-NIB-1){1'b0}}, sum};

   for (genvar g = 0; g < W; g++) begin : g_dec
      if (g < DEC_N) begin : g_used
         assign dec_out[g] = (pattern[DEC_IN-1:0] == g[DEC_IN-1:0]);
      end else begin : g_zero
         assign dec_out[g] = 1'b0;
      end
   end

   assign raw  = (cut_kind_e'(sel_dec) == CUT_DECODER) ? dec_out : add_out;
   assign resp = flt ? (raw | {{(W-1){1'b0}}, 1'b1}) : raw;

   // R5
   dec_onehot_chk: assert property (@(posedge clk) disable iff (rst)
      (sel_dec && !flt) |-> $countones(resp) == 1);
   // R4
   add_range_chk: assert property (@(posedge clk) disable iff (rst)
      (!sel_dec && !flt) |-> resp <= W'(2 * ((1 << NIB) - 1)));

endmodule

// File: rtl/lbist_misr.sv
module lbist_misr #(
   parameter int           W    = 8,
   parameter logic [W-1:0] TAPS = 8'hB8
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         clear,
   input  logic         step,
   input  logic [W-1:0] resp,
   output logic [W-1:0] nxt,
   output logic [W-1:0] state
);

   logic fb;
   assign fb = ^(state & TAPS);

   for (genvar i = 0; i < W; i++) begin : g_stage
      if (i == 0) begin : g_head
         assign nxt[i] = fb ^ resp[i];
      end else begin : g_body
         assign nxt[i] = state[i-1] ^ resp[i];
      end
   end

   always_ff @(posedge clk) begin
      if (rst)        state <= '0;
      else if (clear) state <= '0;
      else if (step)  state <= nxt;
   end

   // R6
   misr_clear_chk: assert property (@(posedge clk) disable iff (rst)
      clear |=> state == '0);
   // R6
   misr_idle_chk: assert property (@(posedge clk) disable iff (rst)
      (!clear && !step) |=> $stable(state));

endmodule

// File: rtl/lbist_engine.sv
module lbist_engine #(
   parameter int           W        = 8,
   parameter logic [W-1:0] TAPS     = lbist_pkg::DEF_TAPS,
   parameter logic [W-1:0] SEED     = lbist_pkg::DEF_SEED,
   parameter int           RUN_LEN  = lbist_pkg::DEF_LEN,
   parameter logic [W-1:0] GOLD_ADD = lbist_pkg::ref_signature(1'b0, 1'b0,
                                        lbist_pkg::DEF_TAPS, lbist_pkg::DEF_SEED,
                                        lbist_pkg::DEF_LEN),
   parameter logic [W-1:0] GOLD_DEC = lbist_pkg::ref_signature(1'b1, 1'b0,
                                        lbist_pkg::DEF_TAPS, lbist_pkg::DEF_SEED,
                                        lbist_pkg::DEF_LEN)
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         start,
   input  logic         cut_sel,
   input  logic         inject_fault,
   output logic         busy,
   output logic         done,
   output logic         pass,
   output logic [W-1:0] signature
);

   localparam int CW = $clog2(RUN_LEN + 1);
   localparam logic [CW-1:0] LAST = CW'(RUN_LEN - 1);

   initial begin
      if (RUN_LEN < 1) $error("lbist_engine: RUN_LEN must be positive");
   end

   logic         accept;
   logic [CW-1:0] cnt;
   logic         sel_q;
   logic         flt_q;
   logic [W-1:0] pattern;
   logic [W-1:0] resp;
   logic [W-1:0] misr_nxt;
   logic [W-1:0] gold;

   assign accept = start && !busy;
   assign gold   = sel_q ? GOLD_DEC : GOLD_ADD;

   lbist_prpg #(.W(W), .TAPS(TAPS), .SEED(SEED)) u_prpg (
      .clk(clk), .rst(rst), .load(accept), .step(busy), .state(pattern));

   lbist_cut #(.W(W)) u_cut (
      .clk(clk), .rst(rst), .pattern(pattern), .sel_dec(sel_q),
      .flt(flt_q), .resp(resp));

   lbist_misr #(.W(W), .TAPS(TAPS)) u_misr (
      .clk(clk), .rst(rst), .clear(accept), .step(busy), .resp(resp),
      .nxt(misr_nxt), .state(signature));

   always_ff @(posedge clk) begin
      if (rst) begin
         busy  <= 1'b0;
         done  <= 1'b0;
         pass  <= 1'b0;
         cnt   <= '0;
         sel_q <= 1'b0;
         flt_q <= 1'b0;
      end else if (accept) begin
         busy  <= 1'b1;
         done  <= 1'b0;
         pass  <= 1'b0;
         cnt   <= '0;
         sel_q <= cut_sel;
         flt_q <= inject_fault;
      end else if (busy) begin
         cnt <= cnt + 1'b1;
         if (cnt == LAST) begin
            busy <= 1'b0;
            done <= 1'b1;
            pass <= (misr_nxt == gold);
         end
      end
   end

   // R2
   busy_done_excl_chk: assert property (@(posedge clk) disable iff (rst)
      !(busy && done));
   // R2
   start_accept_chk: assert property (@(posedge clk) disable iff (rst)
      (start && !busy) |=> busy && !done && !pass);
   // R7
   pass_needs_done_chk: assert property (@(posedge clk) disable iff (rst)
      pass |-> done);
   // R9
   done_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (done && !start) |=> done && $stable(pass) && $stable(signature));
   // R10
   sel_frozen_chk: assert property (@(posedge clk) disable iff (rst)
      (busy && $past(busy)) |-> $stable(sel_q) && $stable(flt_q));

endmodule

// File: tb/lbist_engine_test.sv
module lbist_engine_test;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       start = 1'b0;
   logic       cut_sel = 1'b0;
   logic       inject_fault = 1'b0;
   logic       busy, done, pass;
   logic [7:0] signature;

   int n_chk = 0;
   int n_bad = 0;
   bit timed_out = 1'b0;

   always #4 clk = ~clk;

   lbist_engine uut (
      .clk(clk), .rst(rst), .start(start), .cut_sel(cut_sel),
      .inject_fault(inject_fault), .busy(busy), .done(done), .pass(pass),
      .signature(signature));

   function automatic logic [7:0] model_sig(bit dec, bit flt);
      logic [7:0] p, m, r;
      logic fp, fm;
      p = 8'h01;
      m = 8'h00;
      for (int k = 0; k < 255; k++) begin
         r = 8'h00;
         if (dec) r[p[2:0]] = 1'b1;
         else     r = 8'(p[3:0]) + 8'(p[7:4]);
         if (flt) r[0] = 1'b1;
         fm = m[7] ^ m[5] ^ m[4] ^ m[3];
         m  = {m[6:0], fm} ^ r;
         fp = p[7] ^ p[5] ^ p[4] ^ p[3];
         p  = {p[6:0], fp};
      end
      return m;
   endfunction

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // One full run; optionally disturb inputs mid-run (R10).
   task automatic run(bit dec, bit flt, bit disturb);
      int cyc;
      logic [7:0] exp_sig;
      bit exp_pass;
      @(negedge clk);
      cut_sel = dec; inject_fault = flt; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check("R2 busy after start", busy, 1);
      check("R6 signature cleared", signature, 8'h00);
      cyc = 0;
      while (!done && cyc < 400) begin
         if (disturb && cyc == 40) begin
            cut_sel = ~dec; inject_fault = ~flt; start = 1'b1;
         end
         if (disturb && cyc == 41) start = 1'b0;
         if (busy === done) begin
            check("R2 busy/done exclusive", {busy, done}, 2'b10);
         end
         @(negedge clk);
         cyc++;
      end
      check(disturb ? "R10 run length" : "R2 run length", cyc, 255);
      exp_sig  = model_sig(dec, flt);
      exp_pass = (exp_sig == model_sig(dec, 1'b0));
      if (flt)
         check(disturb ? "R10 R8 signature" : "R8 faulty signature", signature, exp_sig);
      else if (dec)
         check(disturb ? "R10 R5 signature" : "R5 R3 R6 decoder signature", signature, exp_sig);
      else
         check(disturb ? "R10 R4 signature" : "R4 R3 R6 adder signature", signature, exp_sig);
      check(flt ? "R8 pass flag" : "R7 pass flag", pass, exp_pass);
      check("R2 busy low at done", busy, 0);
      cut_sel = dec; inject_fault = flt;
   endtask

   initial begin
      #2_000_000;
      timed_out = 1'b1;
   end

   initial begin
      logic [7:0] held_sig;
      logic held_pass;
      void'($urandom(32'd20240607));
      repeat (3) @(negedge clk);
      check("R1 busy in reset", busy, 0);
      check("R1 done in reset", done, 0);
      rst = 1'b0;
      repeat (4) @(negedge clk);
      check("R1 busy after reset", busy, 0);
      check("R1 done after reset", done, 0);
      check("R1 pass after reset", pass, 0);
      check("R1 signature after reset", signature, 8'h00);

      run(1'b0, 1'b0, 1'b0);
      run(1'b1, 1'b0, 1'b0);
      run(1'b0, 1'b1, 1'b0);
      run(1'b1, 1'b1, 1'b0);

      // R9: results hold while inputs wander
      held_sig  = signature;
      held_pass = pass;
      for (int i = 0; i < 30; i++) begin
         @(negedge clk);
         cut_sel = 1'($urandom); inject_fault = 1'($urandom);
      end
      @(negedge clk);
      check("R9 done held", done, 1);
      check("R9 pass held", pass, held_pass);
      check("R9 signature held", signature, held_sig);

      // R10: disturbances during runs
      run(1'b0, 1'b0, 1'b1);
      run(1'b1, 1'b0, 1'b1);

      for (int j = 0; j < 8 && !timed_out; j++) begin
         run(1'($urandom), 1'($urandom), 1'($urandom));
         repeat ($urandom_range(0, 5)) @(negedge clk);
      end

      if (timed_out) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=hung expected=finished");
      end
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
      $finish;
   end

   initial begin
      wait (timed_out);
      #1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
      $finish;
   end

endmodule